// File: doc/BRIEF.md
# Three-Level IO Address Table Walker

This block turns a device DMA address into a physical address by walking three tables held in memory: a region table, then a segment table, then a page table. A translation starts with a one-cycle `start` pulse. With it come the request address, a read or write flag, the address window and the origin word. The origin word carries the region-table origin and a protection bit.

The walker first checks the address against an inclusive base and limit window. If the address is inside the window, it reads one 64-bit entry per level through a plain memory port. Only one read is ever outstanding. It checks the format of each entry, narrows the permission as it goes, and can stop at the segment level with a 1 MiB frame. When the walk ends, it reports the translated address, the frame size as a power of two, a permission and an error code. It pulses `done` for one cycle and holds the results until the next accepted `start`.

Top module: `iow_walker`

## Requirements
- R1: The walk visits the region, segment and page levels in that order. Each entry is read from `table origin + index*8`, where the region index is address bits [41:31], the segment index bits [30:20] and the page index bits [19:12]. The region-table origin is the origin word with bits [13:0] cleared.
- R2: `mem_req` stays high with a stable `mem_addr` until `mem_ready` is seen. At most one read is outstanding, and only the reads the walk needs are issued.
- R3: A good page entry completes the walk with `xlat_addr = {entry[63:12], addr[11:0]}`. The error code is 0 (none).
- R4: An all-zero entry at any level ends the walk with error 1, permission 00 and `xlat_addr` 0.
- R5: An entry with bit 10 set is invalid at any level. It ends the walk with permission 00 and error 0, including for write requests.
- R6: A region entry with bits [1:0] not equal to 11, or with bits [7:6] nonzero, ends the walk with error 2.
- R7: A region entry whose type bits [3:2] are not 11, or whose bits [63:14] are zero, gives error 3. A segment entry whose type bits [3:2] are not 10, or (without frame control) whose bits [63:11] are zero, gives error 3. A page entry whose bits [63:12] are zero also gives error 3.
- R8: Permission is 11 (read-write) unless bit 9 is set in the origin word or in any entry used. In that case it is 01 (read-only). Permission 00 means none.
- R9: A good segment entry with bit 5 set completes the walk with `xlat_addr = {entry[63:20], addr[19:0]}`.
- R10: `frame_log2` reports the level at which the walk ended: 31 for region, 20 for segment and 12 for page. It is 12 for a window error.
- R11: An address below `win_base` or above `win_limit` gives error 4 and permission 00 with no memory read. Both bounds are inclusive, so they are inside the window.
- R12: A write request whose completed translation is read-only gives error 5. The permission stays 01 and the address is still reported.
- R13: `done` is a one-cycle pulse. The results hold until the next accepted `start`, and a `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a translation (accepted when idle) |
| origin_word | input | 64 | Region-table origin [63:14], protection bit 9 |
| req_addr | input | 64 | Device address to translate |
| req_write | input | 1 | 1 = write access requested |
| win_base | input | 64 | Lowest permitted address |
| win_limit | input | 64 | Highest permitted address |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle result strobe |
| xlat_addr | output | 64 | Translated physical address |
| frame_log2 | output | 6 | log2 of the frame size |
| perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| err_code | output | 3 | 0 none, 1 zero entry, 2 length, 3 type, 4 window, 5 protection |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 64 | Entry read address |
| mem_ready | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read data |

## Verification
The bench goes after the order of the entry checks. A zero entry, a bad length or offset, and a wrong type field each need their own code, while an invalid entry must clear the permission with no code. A design that swapped these checks would report the wrong error or raise a false one.

It checks the 1 MiB early stop, where a walker that ignored frame control would read one more entry and lose the low 20 address bits. It also checks protection coming from the origin word and from a page entry, and that both window bounds are inclusive. A window compare that is off by one would reject the edge addresses. Each read address is compared, including a high region index, and the memory port is stalled to show that a request held without `mem_ready` is not lost or repeated.

// File: rtl/iow_pkg.sv
package iow_pkg;

    typedef enum logic [1:0] {LV_PAGE = 2'd0, LV_SEG = 2'd1, LV_RGN = 2'd2} lvl_e;
    typedef enum logic [1:0] {PERM_NONE = 2'b00, PERM_RO = 2'b01, PERM_RW = 2'b11} perm_e;
    typedef enum logic [2:0] {
        ERR_NONE = 3'd0, ERR_ZERO = 3'd1, ERR_LEN = 3'd2,
        ERR_TYPE = 3'd3, ERR_RANGE = 3'd4, ERR_PROT = 3'd5
    } err_e;
    typedef enum logic [1:0] {CK_NEXT, CK_FINAL, CK_STOP} act_e;

    localparam int BIT_INVALID = 10;
    localparam int BIT_PROT    = 9;
    localparam int BIT_FC      = 5;
    localparam logic [1:0] TYPE_RGN = 2'b11;
    localparam logic [1:0] TYPE_SEG = 2'b10;

    function automatic perm_e narrow(input perm_e p, input logic prot);
        if (prot && p != PERM_NONE) return PERM_RO;
        return p;
    endfunction

endpackage

// File: rtl/iow_ent_addr.sv
module iow_ent_addr
    import iow_pkg::*;
#(
    parameter int PG_SHIFT  = 12,
    parameter int SEG_SHIFT = 20,
    parameter int RGN_SHIFT = 31,
    parameter int PG_IDX_W  = 8,
    parameter int SEG_IDX_W = 11,
    parameter int RGN_IDX_W = 11
) (
    input  logic [63:0] org,
    input  logic [63:0] req_addr,
    input  lvl_e        lvl,
    output logic [63:0] ent_addr
);
    localparam int SH [3] = '{PG_SHIFT, SEG_SHIFT, RGN_SHIFT};
    localparam int IW [3] = '{PG_IDX_W, SEG_IDX_W, RGN_IDX_W};

    logic [63:0] ofs [3];
    logic [63:0] sel;

    for (genvar g = 0; g < 3; g++) begin : g_lvl
        localparam int S = SH[g];
        localparam int W = IW[g];
        assign ofs[g] = {{(61 - W){1'b0}}, req_addr[S +: W], 3'b000};
    end

    always_comb begin
        case (lvl)
            LV_RGN:  sel = ofs[2];
            LV_SEG:  sel = ofs[1];
            default: sel = ofs[0];
        endcase
    end

    assign ent_addr = org + sel;
endmodule

// File: rtl/iow_entry_chk.sv
module iow_entry_chk
    import iow_pkg::*;
#(
    parameter int PG_SHIFT    = 12,
    parameter int SEG_SHIFT   = 20,
    parameter int SEG_ORG_LSB = 14,
    parameter int PG_ORG_LSB  = 11
) (
    input  logic [63:0] entry,
    input  lvl_e        lvl,
    input  logic [63:0] req_addr,
    output act_e        act,
    output err_e        err,
    output logic [63:0] nxt_org,
    output logic [63:0] frame_addr,
    output logic        prot
);
    always_comb begin
        act        = CK_STOP;
        err        = ERR_NONE;
        nxt_org    = '0;
        frame_addr = '0;
        prot       = entry[BIT_PROT];
        if (entry == '0) begin
            err = ERR_ZERO;
        end else if (entry[BIT_INVALID]) begin
            act = CK_STOP;          // invalid: no permission, no code
        end else begin
            case (lvl)
                LV_RGN: begin
                    if (entry[1:0] != 2'b11 || entry[7:6] != 2'b00) begin
                        err = ERR_LEN;
                    end else if (entry[3:2] != TYPE_RGN || entry[63:SEG_ORG_LSB] == '0) begin
                        err = ERR_TYPE;
                    end else begin
                        act     = CK_NEXT;
                        nxt_org = {entry[63:SEG_ORG_LSB], {SEG_ORG_LSB{1'b0}}};
                    end
                end
                LV_SEG: begin
                    if (entry[3:2] != TYPE_SEG) begin
                        err = ERR_TYPE;
                    end else if (entry[BIT_FC]) begin
                        act        = CK_FINAL;
                        frame_addr = {entry[63:SEG_SHIFT], req_addr[SEG_SHIFT-1:0]};
                    end else if (entry[63:PG_ORG_LSB] == '0) begin
                        err = ERR_TYPE;
                    end else begin
                        act     = CK_NEXT;
                        nxt_org = {entry[63:PG_ORG_LSB], {PG_ORG_LSB{1'b0}}};
                    end
                end
                default: begin
                    if (entry[63:PG_SHIFT] == '0) begin
                        err = ERR_TYPE;
                    end else begin
                        act        = CK_FINAL;
                        frame_addr = {entry[63:PG_SHIFT], req_addr[PG_SHIFT-1:0]};
                    end
                end
            endcase
        end
    end

    // a_zero_r4: an all-zero entry always maps to the zero-entry code
    always_comb begin
        if (entry == '0) a_zero_r4: assert (err == ERR_ZERO && act == CK_STOP);
    end
endmodule

// File: rtl/iow_walker.sv
module iow_walker
    import iow_pkg::*;
#(
    parameter int PG_SHIFT  = 12,
    parameter int SEG_SHIFT = 20,
    parameter int RGN_SHIFT = 31,
    parameter int PG_IDX_W  = 8,
    parameter int SEG_IDX_W = 11,
    parameter int RGN_IDX_W = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] origin_word,
    input  logic [63:0] req_addr,
    input  logic        req_write,
    input  logic [63:0] win_base,
    input  logic [63:0] win_limit,
    output logic        busy,
    output logic        done,
    output logic [63:0] xlat_addr,
    output logic [5:0]  frame_log2,
    output logic [1:0]  perm,
    output logic [2:0]  err_code,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_ready,
    input  logic        mem_rvalid,
    input  logic [63:0] mem_rdata
);
    localparam int RGN_ORG_LSB = RGN_IDX_W + 3;
    localparam int SEG_ORG_LSB = SEG_IDX_W + 3;
    localparam int PG_ORG_LSB  = PG_IDX_W + 3;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;

    typedef struct packed {
        st_e         st;
        lvl_e        lvl;
        logic [63:0] org;
        logic [63:0] addr;
        logic        wr;
        perm_e       perm;
        logic [63:0] xlat;
        logic [5:0]  flog;
        err_e        err;
    } walk_t;

    localparam walk_t WALK_RST = '{
        st: S_IDLE, lvl: LV_RGN, org: '0, addr: '0, wr: 1'b0,
        perm: PERM_NONE, xlat: '0, flog: '0, err: ERR_NONE
    };

    walk_t       walk_d, walk_q;
    act_e        ck_act;
    err_e        ck_err;
    logic [63:0] ck_org, ck_frame;
    logic        ck_prot;
    perm_e       perm_nar;

    iow_ent_addr #(
        .PG_SHIFT(PG_SHIFT), .SEG_SHIFT(SEG_SHIFT), .RGN_SHIFT(RGN_SHIFT),
        .PG_IDX_W(PG_IDX_W), .SEG_IDX_W(SEG_IDX_W), .RGN_IDX_W(RGN_IDX_W)
    ) u_addr (
        .org(walk_q.org), .req_addr(walk_q.addr), .lvl(walk_q.lvl), .ent_addr(mem_addr)
    );

    iow_entry_chk #(
        .PG_SHIFT(PG_SHIFT), .SEG_SHIFT(SEG_SHIFT),
        .SEG_ORG_LSB(SEG_ORG_LSB), .PG_ORG_LSB(PG_ORG_LSB)
    ) u_chk (
        .entry(mem_rdata), .lvl(walk_q.lvl), .req_addr(walk_q.addr),
        .act(ck_act), .err(ck_err), .nxt_org(ck_org), .frame_addr(ck_frame), .prot(ck_prot)
    );

    function automatic logic [5:0] flog_of(input lvl_e l);
        case (l)
            LV_RGN:  return 6'(RGN_SHIFT);
            LV_SEG:  return 6'(SEG_SHIFT);
            default: return 6'(PG_SHIFT);
        endcase
    endfunction

    assign perm_nar = narrow(walk_q.perm, ck_prot);

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            S_IDLE: begin
                if (start) begin
                    walk_d.addr = req_addr;
                    walk_d.wr   = req_write;
                    walk_d.xlat = '0;
                    if (req_addr < win_base || req_addr > win_limit) begin
                        walk_d.st   = S_DONE;
                        walk_d.err  = ERR_RANGE;
                        walk_d.perm = PERM_NONE;
                        walk_d.flog = 6'(PG_SHIFT);
                    end else begin
                        walk_d.st   = S_ISSUE;
                        walk_d.lvl  = LV_RGN;
                        walk_d.org  = {origin_word[63:RGN_ORG_LSB], {RGN_ORG_LSB{1'b0}}};
                        walk_d.perm = origin_word[BIT_PROT] ? PERM_RO : PERM_RW;
                        walk_d.err  = ERR_NONE;
                        walk_d.flog = 6'(RGN_SHIFT);
                    end
                end
            end
            S_ISSUE: begin
                if (mem_ready) walk_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rvalid) begin
                    walk_d.flog = flog_of(walk_q.lvl);
                    case (ck_act)
                        CK_NEXT: begin
                            walk_d.org  = ck_org;
                            walk_d.lvl  = (walk_q.lvl == LV_RGN) ? LV_SEG : LV_PAGE;
                            walk_d.perm = perm_nar;
                            walk_d.st   = S_ISSUE;
                        end
                        CK_FINAL: begin
                            walk_d.xlat = ck_frame;
                            walk_d.perm = perm_nar;
                            walk_d.err  = (walk_q.wr && perm_nar != PERM_RW) ? ERR_PROT : ERR_NONE;
                            walk_d.st   = S_DONE;
                        end
                        default: begin
                            walk_d.perm = PERM_NONE;
                            walk_d.err  = ck_err;
                            walk_d.st   = S_DONE;
                        end
                    endcase
                end
            end
            default: walk_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= WALK_RST;
        else        walk_q <= walk_d;
    end

    assign busy       = walk_q.st != S_IDLE;
    assign done       = walk_q.st == S_DONE;
    assign mem_req    = walk_q.st == S_ISSUE;
    assign xlat_addr  = walk_q.xlat;
    assign frame_log2 = walk_q.flog;
    assign perm       = walk_q.perm;
    assign err_code   = walk_q.err;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (req_addr < win_base || req_addr > win_limit))
        |=> (done && err_code == ERR_RANGE));

    p_fail_noperm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != ERR_NONE && err_code != ERR_PROT) |-> (perm == PERM_NONE));

    p_prot_ro_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == ERR_PROT) |-> (perm == PERM_RO));

    p_perm_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (perm != 2'b10));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/iow_walker_tb_top.sv
module iow_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] origin_word = '0;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [63:0] win_base = '0;
    logic [63:0] win_limit = '1;
    logic        busy, done, mem_req;
    logic [63:0] xlat_addr, mem_addr;
    logic [5:0]  frame_log2;
    logic [1:0]  perm;
    logic [2:0]  err_code;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    iow_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .origin_word(origin_word),
        .req_addr(req_addr), .req_write(req_write), .win_base(win_base),
        .win_limit(win_limit), .busy(busy), .done(done), .xlat_addr(xlat_addr),
        .frame_log2(frame_log2), .perm(perm), .err_code(err_code),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory model
    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];
    logic [63:0] hs_addr = '0;
    int hs_num = 0, served = 0, wait_c = 0, lat = 0;
    bit stall = 0, phase = 0;

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            hs_addr <= mem_addr;
            hs_num  <= hs_num + 1;
            if (exp_q.size() == 0) check("R2 unexpected read", mem_addr, 64'hX);
            else check("R1 entry address", mem_addr, exp_q.pop_front());
        end
    end

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (hs_num != served) begin
            if (wait_c >= lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(hs_addr);
                served++;
                wait_c = 0;
            end else wait_c++;
        end
        phase     = ~phase;
        mem_ready = mem_req && (!stall || phase);
        if (rst_n && mem_req && !busy) check("R2 request while idle", 64'd1, 64'd0);
    end

    // behavioural reference
    task automatic ref_walk(input logic [63:0] ow, input logic [63:0] a, input logic wr,
                            output logic [63:0] x, output logic [5:0] fl,
                            output logic [1:0] p, output logic [2:0] e);
        logic [63:0] tbl, ent, idx;
        bit fin;
        exp_q.delete();
        x = 0; e = 0; fin = 0;
        if (a < win_base || a > win_limit) begin fl = 12; p = 0; e = 4; return; end
        tbl = ow & ~64'h3FFF;
        p = ow[9] ? 2'b01 : 2'b11;
        fl = 31;
        for (int lv = 2; lv >= 0 && !fin; lv--) begin
            if (lv == 2)      idx = (a >> 31) & 64'h7FF;
            else if (lv == 1) idx = (a >> 20) & 64'h7FF;
            else              idx = (a >> 12) & 64'hFF;
            exp_q.push_back(tbl + idx * 8);
            ent = rd(tbl + idx * 8);
            fl = (lv == 2) ? 6'd31 : (lv == 1) ? 6'd20 : 6'd12;
            if (ent == 0) begin e = 1; p = 0; return; end
            if (ent[10]) begin p = 0; return; end
            if (lv == 2) begin
                if (ent[1:0] != 2'b11 || ent[7:6] != 0) begin e = 2; p = 0; return; end
                if (ent[3:2] != 2'b11 || (ent >> 14) == 0) begin e = 3; p = 0; return; end
                if (ent[9]) p = 2'b01;
                tbl = ent & ~64'h3FFF;
            end else if (lv == 1) begin
                if (ent[3:2] != 2'b10) begin e = 3; p = 0; return; end
                if (ent[5]) begin
                    if (ent[9]) p = 2'b01;
                    x = (ent & ~64'hFFFFF) | (a & 64'hFFFFF);
                    fin = 1;
                end else begin
                    if ((ent >> 11) == 0) begin e = 3; p = 0; return; end
                    if (ent[9]) p = 2'b01;
                    tbl = ent & ~64'h7FF;
                end
            end else begin
                if ((ent >> 12) == 0) begin e = 3; p = 0; return; end
                if (ent[9]) p = 2'b01;
                x = (ent & ~64'hFFF) | (a & 64'hFFF);
                fin = 1;
            end
        end
        if (wr && p == 2'b01) e = 5;
    endtask

    task automatic run(input string rq, input logic [63:0] ow, input logic [63:0] a,
                       input logic wr, input bit poke);
        logic [63:0] ex; logic [5:0] ef; logic [1:0] ep; logic [2:0] ee;
        bit got;
        ref_walk(ow, a, wr, ex, ef, ep, ee);
        @(negedge clk);
        start = 1'b1; origin_word = ow; req_addr = a; req_write = wr;
        got = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            start = (poke && c == 1);
            if (poke && c == 1) req_addr = a ^ 64'h0000_0000_0010_0000;
            if (done) begin got = 1; break; end
        end
        start = 1'b0;
        if (!got) begin check({rq, " R13 no done"}, 64'd0, 64'd1); return; end
        check({rq, " xlat R3/R9"}, xlat_addr, ex);
        check({rq, " frame R10"}, 64'(frame_log2), 64'(ef));
        check({rq, " perm R8"}, 64'(perm), 64'(ep));
        check({rq, " err"}, 64'(err_code), 64'(ee));
        check({rq, " R2 reads done"}, 64'(exp_q.size()), 64'd0);
        @(negedge clk);
        check({rq, " R13 done pulse"}, 64'(done), 64'd0);
        check({rq, " R13 hold"}, xlat_addr, ex);
    endtask

    localparam logic [63:0] RT = 64'h1_0000, ST = 64'h2_0000, PT = 64'h3_0800, ST2 = 64'h4_0000;
    localparam logic [63:0] A  = 64'h1_8050_7123;   // r=3 s=5 p=7

    initial begin
        mem[RT + 3*8]       = ST | 64'hF;
        mem[ST + 5*8]       = PT | 64'h8;
        mem[PT + 7*8]       = 64'hABCD_E000;
        mem[ST + 6*8]       = 64'h1_2340_0028;       // frame control
        mem[ST + 7*8]       = PT | 64'h408;          // invalid segment
        mem[RT + 5*8]       = ST | 64'hE;            // bad length
        mem[RT + 6*8]       = ST | 64'h4F;           // bad offset
        mem[RT + 7*8]       = ST | 64'hB;            // wrong type
        mem[ST + 9*8]       = PT | 64'h4;            // wrong segment type
        mem[PT + 9*8]       = 64'h1;                 // page frame zero
        mem[RT + 64'h7FF*8] = ST2 | 64'hF;
        mem[ST2]            = 64'h5_5550_0028;

        repeat (3) @(negedge clk);
        check("R13 reset busy", 64'(busy), 64'd0);
        check("R13 reset done", 64'(done), 64'd0);
        check("R2 reset req", 64'(mem_req), 64'd0);
        check("R8 reset perm", 64'(perm), 64'd0);
        rst_n = 1'b1;

        run("R1 R3 page read", RT, A, 1'b0, 0);
        run("R12 rw write", RT, A, 1'b1, 0);
        stall = 1; lat = 2;
        run("R2 stalled port", RT, A, 1'b0, 0);
        stall = 0; lat = 0;
        run("R8 origin prot", RT | 64'h200, A, 1'b0, 0);
        run("R12 write on ro", RT | 64'h200, A, 1'b1, 0);
        mem[PT + 7*8] = 64'hABCD_E200;
        run("R8 page prot", RT, A, 1'b0, 0);
        mem[PT + 7*8] = 64'hABCD_E000;
        run("R9 frame control", RT, 64'h1_8064_5678, 1'b0, 0);
        run("R4 zero region", RT, 64'h2_0000_0000, 1'b0, 0);
        run("R4 zero page", RT, 64'h1_8050_8000, 1'b0, 0);
        run("R5 invalid read", RT, 64'h1_8070_0000, 1'b0, 0);
        run("R5 invalid write", RT, 64'h1_8070_0000, 1'b1, 0);
        run("R6 bad length", RT, 64'h2_8000_0000, 1'b0, 0);
        run("R6 bad offset", RT, 64'h3_0000_0000, 1'b0, 0);
        run("R7 region type", RT, 64'h3_8000_0000, 1'b0, 0);
        run("R7 segment type", RT, 64'h1_8090_0000, 1'b0, 0);
        run("R7 page frame zero", RT, 64'h1_8050_9000, 1'b0, 0);
        run("R1 high region index", RT, 64'h3FF_8000_0ABC, 1'b0, 0);
        run("R13 start while busy", RT, A, 1'b0, 1);
        win_base = 64'h1_0000_0000; win_limit = 64'h1_FFFF_FFFF;
        run("R11 inside", RT, A, 1'b0, 0);
        run("R11 below", RT, 64'hFFFF_FFFF, 1'b0, 0);
        run("R11 above", RT, 64'h2_0000_0000, 1'b0, 0);
        run("R11 at base", RT, 64'h1_0000_0000, 1'b0, 0);
        run("R11 at limit", RT, 64'h1_FFFF_FFFF, 1'b0, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R13 watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule